// File: doc/BRIEF.md
# Bridge Read Prefetch Controller

This block sits on the read path of a bus bridge. For each read request an initiator presents, it decides whether the bridge may fetch ahead speculatively or must fetch exactly one dword. It then issues one target-side request that carries a dword-aligned address, a dword count, the byte enables to drive and a flag telling the initiator side to disconnect after the first data transfer.

The choice depends on the command code, on the direction of the transfer and, for plain memory reads, on a prefetchable address window (base and limit) or a prefetch-disable control bit. Line and multiple reads always fetch ahead. I/O and configuration reads always fetch a single dword. A burst is trimmed by the free read-buffer space and by a 4 KB address boundary. A line read is also trimmed at the end of its 8-dword cache line. A speculative read drives all byte enables active. A single-dword read forwards the initiator's byte enables unchanged.

The request enters through a valid/ready handshake. The block holds one result at a time and keeps it stable until the target side takes it.

Top module: `rd_fetch_ctrl`

## Requirements
- R1: Memory read line (cmd 4'b1110) and memory read multiple (cmd 4'b1100) always prefetch (disconnect flag 0), whatever the address, direction or disable bit.
- R2: A memory read (cmd 4'b0110) travelling downstream (upstream=0) prefetches exactly when base <= address <= limit, with all three compared dword-aligned (bits 1:0 cleared). Otherwise it is a single-dword read.
- R3: A memory read travelling upstream (upstream=1) prefetches when pf_disable is 0 and is a single-dword read when pf_disable is 1.
- R4: I/O reads (cmd 4'b0010), configuration reads (cmd 4'b1010) and memory reads that do not prefetch produce count 1 and disconnect flag 1.
- R5: On a single-dword read, tgt_be equals the initiator's byte enables bit for bit.
- R6: On a prefetching read, tgt_be is 4'b1111 and the disconnect flag is 0.
- R7: A prefetching memory read or memory read multiple has count = min(buf_free, dwords left before the next 4 KB boundary), with a minimum of 1.
- R8: A memory read line has count = min(buf_free, dwords left to the end of the 8-dword line, dwords left before the 4 KB boundary), with a minimum of 1.
- R9: tgt_valid rises on the clock edge after a read request is accepted. While tgt_valid is 1 and tgt_ready is 0, every target output holds stable and req_ready is 0.
- R10: A request with any other command code is accepted and produces no target request.
- R11: After reset, tgt_valid is 0 and req_ready is 1.
- R12: tgt_addr is the request address with bits 1:0 cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Initiator read request present |
| req_ready | output | 1 | Block can take a request |
| req_cmd | input | 4 | Bus command code |
| req_upstream | input | 1 | 1 = upstream transfer, 0 = downstream |
| req_addr | input | 32 | Request byte address |
| req_be | input | 4 | Initiator byte enables, active high |
| buf_free | input | FREE_W | Free read-buffer space in dwords |
| win_base | input | 32 | Prefetchable window base |
| win_limit | input | 32 | Prefetchable window limit (inclusive) |
| pf_disable | input | 1 | Turns off upstream prefetch of plain memory reads |
| tgt_valid | output | 1 | Target request pending |
| tgt_ready | input | 1 | Target side accepts the request |
| tgt_addr | output | 32 | Dword-aligned start address |
| tgt_count | output | CNT_W | Dwords to fetch |
| tgt_be | output | 4 | Byte enables for every data phase |
| tgt_disc | output | 1 | Disconnect the initiator after the first dword |

## Verification
Every target output comes from one register. The fields of an accepted read are therefore due on the first clock edge after the accepting edge, and they clear on the edge where tgt_ready is sampled high. The bench drives on falling edges and samples on the next falling edge after each edge that matters. It compares all fields against a model of the requirements. It repeats the comparison during extra stall cycles, to show that the fields hold and that req_ready stays low. For a non-read command the bench checks one edge after acceptance that tgt_valid has stayed low.

// File: rtl/rd_fetch_pkg.sv
package rd_fetch_pkg;

    localparam logic [3:0] CMD_IO_RD       = 4'b0010;
    localparam logic [3:0] CMD_MEM_RD      = 4'b0110;
    localparam logic [3:0] CMD_CFG_RD      = 4'b1010;
    localparam logic [3:0] CMD_MEM_RD_MULT = 4'b1100;
    localparam logic [3:0] CMD_MEM_RD_LINE = 4'b1110;

    // How a request is fetched on the target side
    typedef enum logic [1:0] {
        FK_NONE   = 2'd0,   // not a read: dropped
        FK_SINGLE = 2'd1,   // one dword, forwarded byte enables
        FK_LINE   = 2'd2,   // speculative, stops at cache line end
        FK_BURST  = 2'd3    // speculative, buffer/boundary limited
    } fetch_kind_e;

endpackage

// File: rtl/rd_fetch_classify.sv
module rd_fetch_classify
    import rd_fetch_pkg::*;
(
    input  logic [3:0]  cmd,
    input  logic        upstream,
    input  logic [31:0] addr,
    input  logic [31:0] win_base,
    input  logic [31:0] win_limit,
    input  logic        pf_disable,
    output fetch_kind_e kind
);

    logic [31:0] addr_dw, base_dw, limit_dw;
    logic        in_window;
    logic        mem_pf;

    always_comb begin
        addr_dw   = addr      & 32'hFFFF_FFFC;
        base_dw   = win_base  & 32'hFFFF_FFFC;
        limit_dw  = win_limit & 32'hFFFF_FFFC;
        in_window = (addr_dw >= base_dw) && (addr_dw <= limit_dw);
        mem_pf    = upstream ? !pf_disable : in_window;

        case (cmd)
            CMD_MEM_RD_LINE: kind = FK_LINE;
            CMD_MEM_RD_MULT: kind = FK_BURST;
            CMD_MEM_RD:      kind = mem_pf ? FK_BURST : FK_SINGLE;
            CMD_IO_RD,
            CMD_CFG_RD:      kind = FK_SINGLE;
            default:         kind = FK_NONE;
        endcase
    end

endmodule

// File: rtl/rd_fetch_sizer.sv
module rd_fetch_sizer
    import rd_fetch_pkg::*;
#(
    parameter int BOUND_DW = 1024,
    parameter int LINE_DW  = 8,
    parameter int FREE_W   = 11,
    localparam int IDX_W   = $clog2(BOUND_DW),
    localparam int CNT_W   = IDX_W + 1
) (
    input  fetch_kind_e      kind,
    input  logic [IDX_W-1:0] dw_idx,
    input  logic [FREE_W-1:0] buf_free,
    output logic [CNT_W-1:0] count
);

    localparam int LINE_W = $clog2(LINE_DW);
    localparam int W      = (FREE_W > CNT_W) ? FREE_W : CNT_W;

    logic [W-1:0] to_bound, to_line, room, pick;

    always_comb begin
        to_bound = W'(BOUND_DW) - W'(dw_idx);
        to_line  = W'(LINE_DW) - W'(dw_idx[LINE_W-1:0]);
        room     = W'(buf_free);
        pick     = (room < to_bound) ? room : to_bound;
        if (kind == FK_LINE && to_line < pick) begin
            pick = to_line;
        end
        if (pick == '0) begin
            pick = W'(1);
        end
        if (kind == FK_LINE || kind == FK_BURST) begin
            count = CNT_W'(pick);
        end else begin
            count = CNT_W'(1);
        end
    end

endmodule

// File: rtl/rd_fetch_ctrl.sv
module rd_fetch_ctrl
    import rd_fetch_pkg::*;
#(
    parameter int BOUND_BYTES = 4096,
    parameter int LINE_DW     = 8,
    parameter int FREE_W      = 11,
    localparam int BOUND_DW   = BOUND_BYTES / 4,
    localparam int IDX_W      = $clog2(BOUND_DW),
    localparam int CNT_W      = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [3:0]        req_cmd,
    input  logic              req_upstream,
    input  logic [31:0]       req_addr,
    input  logic [3:0]        req_be,
    input  logic [FREE_W-1:0] buf_free,
    input  logic [31:0]       win_base,
    input  logic [31:0]       win_limit,
    input  logic              pf_disable,
    output logic              tgt_valid,
    input  logic              tgt_ready,
    output logic [31:0]       tgt_addr,
    output logic [CNT_W-1:0]  tgt_count,
    output logic [3:0]        tgt_be,
    output logic              tgt_disc
);

    typedef struct packed {
        logic             vld;
        logic [31:0]      addr;
        logic [CNT_W-1:0] cnt;
        logic [3:0]       be;
        logic             disc;
    } slot_t;

    slot_t            slot_d, slot_q;
    fetch_kind_e      kind;
    logic [CNT_W-1:0] sized_cnt;
    logic             take;

    rd_fetch_classify u_class (
        .cmd        (req_cmd),
        .upstream   (req_upstream),
        .addr       (req_addr),
        .win_base   (win_base),
        .win_limit  (win_limit),
        .pf_disable (pf_disable),
        .kind       (kind)
    );

    rd_fetch_sizer #(
        .BOUND_DW (BOUND_DW),
        .LINE_DW  (LINE_DW),
        .FREE_W   (FREE_W)
    ) u_size (
        .kind     (kind),
        .dw_idx   (req_addr[IDX_W+1:2]),
        .buf_free (buf_free),
        .count    (sized_cnt)
    );

    always_comb begin
        req_ready = !slot_q.vld;
        take      = req_valid && req_ready;
        slot_d    = slot_q;

        if (slot_q.vld && tgt_ready) begin
            slot_d.vld = 1'b0;
        end

        if (take && kind != FK_NONE) begin
            slot_d.vld  = 1'b1;
            slot_d.addr = {req_addr[31:2], 2'b00};
            slot_d.cnt  = sized_cnt;
            if (kind == FK_SINGLE) begin
                slot_d.be   = req_be;
                slot_d.disc = 1'b1;
            end else begin
                slot_d.be   = 4'hF;
                slot_d.disc = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_q <= '0;
        end else begin
            slot_q <= slot_d;
        end
    end

    assign tgt_valid = slot_q.vld;
    assign tgt_addr  = slot_q.addr;
    assign tgt_count = slot_q.cnt;
    assign tgt_be    = slot_q.be;
    assign tgt_disc  = slot_q.disc;

endmodule

// File: rtl/rd_fetch_chk.sv
module rd_fetch_chk #(
    parameter int BOUND_DW = 1024,
    parameter int CNT_W    = 11
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic [3:0]       req_cmd,
    input logic             tgt_valid,
    input logic             tgt_ready,
    input logic [31:0]      tgt_addr,
    input logic [CNT_W-1:0] tgt_count,
    input logic [3:0]       tgt_be,
    input logic             tgt_disc
);

    localparam int IDX_W = $clog2(BOUND_DW);

    logic is_read;
    assign is_read = (req_cmd == 4'b0010) || (req_cmd == 4'b0110) ||
                     (req_cmd == 4'b1010) || (req_cmd == 4'b1100) ||
                     (req_cmd == 4'b1110);

    a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_valid && !tgt_ready |=> tgt_valid && $stable(tgt_addr) &&
        $stable(tgt_count) && $stable(tgt_be) && $stable(tgt_disc));

    a_r9_busy: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_valid |-> !req_ready);

    a_r9_launch: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && is_read |=> tgt_valid);

    a_r10_drop: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && !is_read |=> !tgt_valid);

    a_r6_all_be: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_valid && !tgt_disc |-> tgt_be == 4'hF);

    a_r4_one_dword: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_valid && tgt_disc |-> tgt_count == CNT_W'(1));

    a_r7_in_bound: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_valid |-> (tgt_count != '0) &&
        (32'(tgt_addr[IDX_W+1:2]) + 32'(tgt_count) <= 32'(BOUND_DW)));

    a_r12_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_valid |-> tgt_addr[1:0] == 2'b00);

endmodule

bind rd_fetch_ctrl rd_fetch_chk #(
    .BOUND_DW (BOUND_DW),
    .CNT_W    (CNT_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_cmd   (req_cmd),
    .tgt_valid (tgt_valid),
    .tgt_ready (tgt_ready),
    .tgt_addr  (tgt_addr),
    .tgt_count (tgt_count),
    .tgt_be    (tgt_be),
    .tgt_disc  (tgt_disc)
);

// File: tb/rd_fetch_ctrl_tb.sv
`timescale 1ns/1ps
module rd_fetch_ctrl_tb_top;

    localparam int FREE_W = 11;
    localparam int CNT_W  = 11;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [3:0]        req_cmd = '0;
    logic              req_upstream = 1'b0;
    logic [31:0]       req_addr = '0;
    logic [3:0]        req_be = '0;
    logic [FREE_W-1:0] buf_free = '0;
    logic [31:0]       win_base = '0;
    logic [31:0]       win_limit = '0;
    logic              pf_disable = 1'b0;
    logic              tgt_valid;
    logic              tgt_ready = 1'b0;
    logic [31:0]       tgt_addr;
    logic [CNT_W-1:0]  tgt_count;
    logic [3:0]        tgt_be;
    logic              tgt_disc;

    int n_tests = 0;
    int n_fail  = 0;

    always #2 clk = ~clk;

    rd_fetch_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_cmd(req_cmd), .req_upstream(req_upstream), .req_addr(req_addr),
        .req_be(req_be), .buf_free(buf_free), .win_base(win_base),
        .win_limit(win_limit), .pf_disable(pf_disable), .tgt_valid(tgt_valid),
        .tgt_ready(tgt_ready), .tgt_addr(tgt_addr), .tgt_count(tgt_count),
        .tgt_be(tgt_be), .tgt_disc(tgt_disc)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    function automatic bit is_rd(input logic [3:0] c);
        return c == 4'b0010 || c == 4'b0110 || c == 4'b1010 ||
               c == 4'b1100 || c == 4'b1110;
    endfunction

    function automatic bit exp_pf(input logic [3:0] c, input logic up,
                                  input logic [31:0] a);
        logic [31:0] aa, bb, ll;
        aa = {a[31:2], 2'b00};
        bb = {win_base[31:2], 2'b00};
        ll = {win_limit[31:2], 2'b00};
        if (c == 4'b1110 || c == 4'b1100) return 1'b1;
        if (c == 4'b0110) return up ? !pf_disable : (aa >= bb && aa <= ll);
        return 1'b0;
    endfunction

    function automatic int exp_cnt(input logic [3:0] c, input logic up,
                                   input logic [31:0] a);
        int n;
        if (!exp_pf(c, up, a)) return 1;
        n = 1024 - int'(a[11:2]);
        if (int'(buf_free) < n) n = int'(buf_free);
        if (c == 4'b1110 && (8 - int'(a[4:2])) < n) n = 8 - int'(a[4:2]);
        if (n < 1) n = 1;
        return n;
    endfunction

    function automatic string tag_for(input logic [3:0] c, input logic up);
        if (c == 4'b1110) return "R8";
        if (c == 4'b1100) return "R7";
        if (c == 4'b0110) return up ? "R3" : "R2";
        return "R4";
    endfunction

    task automatic run_req(input logic [3:0] c, input logic up,
                           input logic [31:0] a, input logic [3:0] be,
                           input int hold);
        bit pf;
        int cnt;
        string t;
        @(negedge clk);
        req_cmd = c; req_upstream = up; req_addr = a; req_be = be; req_valid = 1'b1;
        check(req_ready == 1'b1, "R9", "req_ready idle", longint'(req_ready), 1);
        pf  = exp_pf(c, up, a);
        cnt = exp_cnt(c, up, a);
        t   = tag_for(c, up);
        @(negedge clk);
        req_valid = 1'b0;
        if (!is_rd(c)) begin
            check(tgt_valid == 1'b0, "R10", "no request for non-read", longint'(tgt_valid), 0);
            return;
        end
        for (int h = 0; h <= hold; h++) begin
            if (h > 0) @(negedge clk);
            check(tgt_valid == 1'b1, "R9", "tgt_valid", longint'(tgt_valid), 1);
            check(tgt_addr == {a[31:2], 2'b00}, "R12", "tgt_addr",
                  longint'(tgt_addr), longint'({a[31:2], 2'b00}));
            check(tgt_disc == !pf, (c == 4'b1110 || c == 4'b1100) ? "R1" : t,
                  "tgt_disc", longint'(tgt_disc), longint'(!pf));
            check(int'(tgt_count) == cnt, t, "tgt_count", longint'(tgt_count), longint'(cnt));
            check(tgt_be == (pf ? 4'hF : be), pf ? "R6" : "R5", "tgt_be",
                  longint'(tgt_be), longint'(pf ? 4'hF : be));
            if (h > 0)
                check(req_ready == 1'b0, "R9", "req_ready while stalled", longint'(req_ready), 0);
        end
        tgt_ready = 1'b1;
        @(negedge clk);
        tgt_ready = 1'b0;
        check(tgt_valid == 1'b0, "R9", "tgt_valid after accept", longint'(tgt_valid), 0);
    endtask

    initial begin
        #(4 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [3:0] cmds [6];
        void'($urandom(32'd20240917));
        cmds = '{4'b0010, 4'b0110, 4'b1010, 4'b1100, 4'b1110, 4'b0111};
        win_base  = 32'h8000_0000;
        win_limit = 32'h8000_0FFF;
        buf_free  = 11'd64;
        repeat (3) @(negedge clk);
        check(tgt_valid == 1'b0, "R11", "tgt_valid at reset", longint'(tgt_valid), 0);
        check(req_ready == 1'b1, "R11", "req_ready at reset", longint'(req_ready), 1);
        rst_n = 1'b1;

        // R1: line/multiple prefetch outside window, disable set
        pf_disable = 1'b1;
        run_req(4'b1100, 1'b0, 32'h0000_0100, 4'h1, 0);
        run_req(4'b1110, 1'b1, 32'h0000_010C, 4'h2, 0);
        pf_disable = 1'b0;
        // R2: window edges
        run_req(4'b0110, 1'b0, 32'h8000_0000, 4'h3, 0);
        run_req(4'b0110, 1'b0, 32'h8000_0FFE, 4'h3, 0);
        run_req(4'b0110, 1'b0, 32'h8000_1000, 4'h6, 0);
        run_req(4'b0110, 1'b0, 32'h7FFF_FFFC, 4'h9, 0);
        // R3: upstream with and without disable
        run_req(4'b0110, 1'b1, 32'h0000_2000, 4'h5, 0);
        pf_disable = 1'b1;
        run_req(4'b0110, 1'b1, 32'h0000_2000, 4'h5, 0);
        pf_disable = 1'b0;
        // R4/R5: I/O and config reads forward byte enables
        run_req(4'b0010, 1'b0, 32'h0000_03F9, 4'hA, 0);
        run_req(4'b1010, 1'b1, 32'h0000_0044, 4'h0, 0);
        // R7: boundary and buffer limits
        buf_free = 11'd2047;
        run_req(4'b1100, 1'b0, 32'h0000_1F00, 4'h0, 0);
        run_req(4'b1100, 1'b0, 32'h0000_1FFC, 4'h0, 0);
        buf_free = 11'd5;
        run_req(4'b1100, 1'b0, 32'h0000_1000, 4'h0, 0);
        buf_free = 11'd0;
        run_req(4'b1100, 1'b0, 32'h0000_1000, 4'h0, 0);
        // R8: line end
        buf_free = 11'd64;
        run_req(4'b1110, 1'b0, 32'h0000_000C, 4'h0, 0);
        run_req(4'b1110, 1'b0, 32'h0000_001C, 4'h0, 0);
        buf_free = 11'd2;
        run_req(4'b1110, 1'b0, 32'h0000_0000, 4'h0, 0);
        // R9: stall hold
        buf_free = 11'd64;
        run_req(4'b1100, 1'b0, 32'h0000_0400, 4'h0, 3);
        // R10: non-read commands
        run_req(4'b0111, 1'b0, 32'h8000_0010, 4'hF, 0);
        run_req(4'b0000, 1'b1, 32'h0000_0000, 4'hF, 0);

        for (int i = 0; i < 300; i++) begin
            logic [31:0] a;
            a = $urandom();
            if ($urandom_range(0, 1) == 1) a = 32'h8000_0000 | (a & 32'h0000_1FFF);
            buf_free   = FREE_W'($urandom_range(0, 2047));
            pf_disable = 1'($urandom_range(0, 1));
            run_req(cmds[$urandom_range(0, 5)], 1'($urandom_range(0, 1)), a,
                    4'($urandom()), $urandom_range(0, 2));
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule